// File: doc/BRIEF.md
# Synchronous Burst SRAM with Lane Writes

This block is a single-port synchronous static RAM for use as a processor's secondary cache. Address, write data and every control input are captured on the rising clock edge. A 2-bit burst counter then supplies up to four consecutive word addresses from one captured start address. A burst opens on either of two address strobes: one belongs to the processor side and the other to the cache-controller side. After that, each cycle with the advance input low steps to the next beat. The beat order is linear or interleaved. It is fixed by an order-select input that is sampled when the burst opens.

Writes are self-timed. The data captured with a write cycle is committed to the array at the following edge. A write covers every lane through the global-write input, or a chosen subset of lanes through the lane-write enable together with per-lane selects. Reads are flow-through: the addressed word goes straight from the array to the read port, with no output register. The shared data bus is modelled as a separate write-data input and read-data output. The high-impedance state is modelled as a read-valid flag, and the read data is forced to zero while the flag is low.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset no burst is open, `rvalid` is low and `rdata` is zero until a strobe opens a burst.
- R2: A strobe (`strb_cpu_n` or `strb_ctl_n` low) with `sel_n` low loads `addr` as beat 0 of a new burst. A strobe with `sel_n` high closes any open burst. The cycle then neither reads nor writes, and later advance or write inputs have no effect until a new burst opens.
- R3: With a burst open and both strobes high, `adv_n` low steps the 2-bit beat counter. The counter wraps from beat 3 to beat 0. Address bits above bit 1 never change within a burst.
- R4: With `order_il` low at burst start, the low two address bits of beat k are (start + k) mod 4.
- R5: With `order_il` high at burst start, the low two address bits of beat k are start XOR k.
- R6: With a burst open, both strobes high and `adv_n` high, the address is held and the access repeats at the same word.
- R7: `wr_all_n` low writes all lanes, whatever the values of `wr_lane_n` and `lane_n`.
- R8: With `wr_all_n` high and `wr_lane_n` low, exactly the lanes whose `lane_n` bit is low are written. Lane i is data bits [9i+8:9i].
- R9: A cycle whose burst is opened by `strb_cpu_n` is always a read, and any write inputs in that cycle are ignored.
- R10: A read cycle of an open burst shows the addressed word on `rdata`, with `rvalid` high, after the same edge that captured its controls, provided `oe_n` is low. Write cycles and cycles with `oe_n` high give `rvalid` low and `rdata` zero.
- R11: An access with no lane selected (`wr_all_n` and `wr_lane_n` both high, or `wr_lane_n` low with all `lane_n` bits high) is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Burst start address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved |
| sel_n | input | 1 | Device select, sampled with a strobe, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_n | input | 1 | Lane-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data, zero when not valid |
| rvalid | output | 1 | Read data driven (stands for the bus not being high impedance) |

## Verification
Two situations are hard to reach from the ports. One is the wrap from beat 3 back to beat 0, seen in both orders and from every start offset. The other is the interaction of a write-carrying cycle with a processor strobe or a deselect. The stimulus fills the whole array with full-width bursts. It then reads a five-beat burst from each of the 64 start addresses in both orders, alternating the two strobes, so every wrap and start offset is visited. Lane-masked writes, global writes with noisy lane selects, processor-strobe cycles carrying writes and deselected bursts with advance and write held low are each followed by reads. Those reads expose any lane or word that should have been left untouched.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Low two address bits of beat k for a burst starting at s.
    function automatic logic [1:0] beat_low(input logic [1:0] s,
                                            input logic [1:0] k,
                                            input logic       il);
        logic [1:0] r;
        if (il) r = s ^ k;
        else    r = s + k;
        return r;
    endfunction

endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        cnt,
    input  logic              il,
    output logic [ADDR_W-1:0] eff_addr
);
    import sbs_pkg::*;

    always_comb begin
        eff_addr      = base;
        eff_addr[1:0] = beat_low(base[1:0], cnt, il);
    end
endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             active,
    input  logic             cpu_start,
    input  logic             wr_all_n,
    input  logic             wr_lane_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] mask
);
    always_comb begin
        if (!active || cpu_start) mask = '0;
        else if (!wr_all_n)       mask = '1;
        else if (!wr_lane_n)      mask = ~lane_n;
        else                      mask = '0;
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES*LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (we[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strb_cpu_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic                    order_il,
    input  logic                    sel_n,
    input  logic                    wr_all_n,
    input  logic                    wr_lane_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        logic              il;
        logic              open;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] wd;
    } st_t;

    st_t st_d, st_q;

    logic              strobe_w, start_w, desel_w, cpu_start_w, active_w;
    logic [LANES-1:0]  mask_w;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] arr_rd;
    logic              rd_op;

    assign strobe_w    = !strb_cpu_n || !strb_ctl_n;
    assign start_w     = strobe_w && !sel_n;
    assign desel_w     = strobe_w && sel_n;
    assign cpu_start_w = start_w && !strb_cpu_n;
    assign active_w    = start_w || (st_q.open && !desel_w);

    sbs_lane_dec #(.LANES(LANES)) u_lane (
        .active    (active_w),
        .cpu_start (cpu_start_w),
        .wr_all_n  (wr_all_n),
        .wr_lane_n (wr_lane_n),
        .lane_n    (lane_n),
        .mask      (mask_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_w;
        st_d.wd   = wdata;
        if (start_w) begin
            st_d.base = addr;
            st_d.cnt  = 2'd0;
            st_d.il   = order_il;
            st_d.open = 1'b1;
        end else if (desel_w) begin
            st_d.open = 1'b0;
        end else if (!adv_n && st_q.open) begin
            st_d.cnt = st_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base     (st_q.base),
        .cnt      (st_q.cnt),
        .il       (st_q.il),
        .eff_addr (eff_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (st_q.mask),
        .addr  (eff_addr),
        .wdata (st_q.wd),
        .rdata (arr_rd)
    );

    assign rd_op  = st_q.open && (st_q.mask == '0);
    assign rvalid = rd_op && !oe_n;
    assign rdata  = rvalid ? arr_rd : '0;

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (eff_addr == $past(addr)));

    assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        desel_w |=> (!rvalid && st_q.mask == '0));

    assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && !strobe_w && !adv_n) |=>
        (st_q.cnt == 2'($past(st_q.cnt) + 2'd1) &&
         eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_w && adv_n) |=> $stable(eff_addr));

    assert_global_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && !cpu_start_w && !wr_all_n) |=> (st_q.mask == {LANES{1'b1}}));

    assert_cpu_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_start_w |=> (st_q.mask == '0));

    assert_closed_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.open && !start_w) |=> (!rvalid && rdata == '0));
endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic          order_il = 1'b0, sel_n = 1'b0;
    logic          wr_all_n = 1'b1, wr_lane_n = 1'b1;
    logic [LN-1:0] lane_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
        .clk, .rst_n, .addr, .strb_cpu_n, .strb_ctl_n, .adv_n, .order_il,
        .sel_n, .wr_all_n, .wr_lane_n, .lane_n, .oe_n, .wdata, .rdata, .rvalid
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [1<<AW];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_k = '0;
    logic          m_il = 1'b0;
    logic          m_open = 1'b0;

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    task automatic check_out(input logic exp_v, input logic [DW-1:0] exp_d, input string tag);
        checks++;
        if (rvalid !== exp_v || rdata !== exp_d) begin
            errors++;
            $display("FAIL %s rvalid/rdata act=%0b/%h exp=%0b/%h", tag, rvalid, rdata, exp_v, exp_d);
        end
    endtask

    // One clock cycle: drive after the falling edge, update the model at the
    // rising edge, compare 2 ns later.
    task automatic cyc(input logic cpu_n, input logic ctl_n, input logic av_n,
                       input logic sl_n, input logic wa_n, input logic wl_n,
                       input logic [LN-1:0] ln, input logic [AW-1:0] a,
                       input logic il, input logic o_n, input string tag);
        logic          strobe, start;
        logic [LN-1:0] msk;
        logic [AW-1:0] ea;
        logic [1:0]    lo;
        logic [DW-1:0] wd;
        logic          ev;
        logic [DW-1:0] ed;
        @(negedge clk);
        wd = rnd_word();
        strb_cpu_n = cpu_n; strb_ctl_n = ctl_n; adv_n = av_n; sel_n = sl_n;
        wr_all_n = wa_n; wr_lane_n = wl_n; lane_n = ln; addr = a;
        order_il = il; oe_n = o_n; wdata = wd;
        @(posedge clk);
        strobe = !cpu_n || !ctl_n;
        start  = strobe && !sl_n;
        if (start) begin
            m_base = a; m_k = 2'd0; m_il = il; m_open = 1'b1;
        end else if (strobe) begin
            m_open = 1'b0;
        end else if (!av_n && m_open) begin
            m_k = m_k + 2'd1;
        end
        lo = m_il ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k);
        ea = {m_base[AW-1:2], lo};
        if (!wa_n)      msk = '1;
        else if (!wl_n) msk = ~ln;
        else            msk = '0;
        if (!m_open || (start && !cpu_n)) msk = '0;
        ev = 1'b0;
        ed = '0;
        if (msk != '0) begin
            for (int i = 0; i < LN; i++)
                if (msk[i]) ref_mem[ea][i*LW +: LW] = wd[i*LW +: LW];
        end else if (m_open && !o_n) begin
            ev = 1'b1;
            ed = ref_mem[ea];
        end
        #2;
        check_out(ev, ed, tag);
    endtask

    task automatic idle_cyc(input string tag);
        cyc(1, 1, 1, 0, 1, 1, '1, '0, 0, 0, tag);
    endtask

    // Five-beat read burst: beat 0 plus four advances, the last one wrapping.
    task automatic rd_burst(input logic [AW-1:0] a, input logic il, input logic use_cpu);
        string t;
        t = il ? "R5" : "R4";
        cyc(!use_cpu, use_cpu, 1, 0, 1, 1, '1, a, il, 0, t);
        for (int b = 1; b < 4; b++) cyc(1, 1, 0, 0, 1, 1, '1, '0, 0, 0, t);
        cyc(1, 1, 0, 0, 1, 1, '1, '0, 0, 0, "R3");
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic il,
                            input logic wa_n, input logic wl_n,
                            input logic [LN-1:0] ln, input string tag);
        cyc(1, 0, 1, 0, wa_n, wl_n, ln, a, il, 0, tag);
        for (int b = 1; b < 4; b++) cyc(1, 1, 0, 0, wa_n, wl_n, ln, '0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        check_out(1'b0, '0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle_cyc("R1");
        cyc(1, 1, 0, 0, 0, 1, '1, '0, 0, 0, "R1");

        // Fill the array with full-lane bursts (R7).
        for (int blk = 0; blk < (1 << AW) / 4; blk++)
            wr_burst(AW'(blk * 4), 1'b0, 1'b0, 1'b1, '1, "R7");

        // Every start address, both orders, alternating strobes (R4, R5, R3, R10).
        for (int il = 0; il < 2; il++)
            for (int a = 0; a < (1 << AW); a++)
                rd_burst(AW'(a), il[0], a[0]);

        // Hold without advance (R6).
        for (int a = 0; a < 8; a++) begin
            cyc(1, 0, 1, 0, 1, 1, '1, AW'(a * 7), a[1], 0, "R6");
            cyc(1, 1, 0, 0, 1, 1, '1, '0, 0, 0, "R6");
            idle_cyc("R6");
            idle_cyc("R6");
        end

        // Lane-masked writes, every lane pattern (R8, R11), then read back.
        for (int m = 0; m < 16; m++) begin
            wr_burst(AW'(m * 4 + 1), 1'b1, 1'b1, 1'b0, LN'(m), (m == 15) ? "R11" : "R8");
            rd_burst(AW'(m * 4 + 1), 1'b1, 1'b0);
        end

        // No write enable at all with lane selects low (R11).
        wr_burst(AW'(5), 1'b0, 1'b1, 1'b1, '0, "R11");
        rd_burst(AW'(5), 1'b0, 1'b0);

        // Global write overriding lane selects (R7).
        for (int m = 0; m < 16; m++) begin
            wr_burst(AW'(m * 4 + 2), 1'b0, 1'b0, m[0], LN'(m), "R7");
            rd_burst(AW'(m * 4 + 2), 1'b0, 1'b1);
        end

        // Processor-strobe cycles carrying writes stay reads (R9).
        for (int a = 0; a < 16; a++) begin
            cyc(0, a[0], 1, 0, 0, 0, '0, AW'(a * 3), a[1], 0, "R9");
            rd_burst(AW'(a * 3), 1'b0, 1'b0);
        end

        // Deselect closes the burst; later advance and writes do nothing (R2).
        for (int a = 0; a < 8; a++) begin
            cyc(1, 0, 1, 0, 1, 1, '1, AW'(a * 8 + 3), 0, 0, "R2");
            cyc(a[0], !a[0], 1, 1, 0, 0, '0, AW'(a * 8 + 3), 0, 0, "R2");
            cyc(1, 1, 0, 0, 0, 0, '0, '0, 0, 0, "R2");
            cyc(1, 1, 1, 0, 0, 1, '1, '0, 0, 0, "R2");
            rd_burst(AW'(a * 8), 1'b0, 1'b0);
        end

        // Output enable high masks the read (R10).
        cyc(1, 0, 1, 0, 1, 1, '1, AW'(9), 0, 1, "R10");
        cyc(1, 1, 0, 0, 1, 1, '1, '0, 0, 0, "R10");
        cyc(1, 1, 0, 0, 1, 1, '1, '0, 0, 1, "R10");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule